// File: doc/BRIEF.md
# Indirect Control RAM Access Port

This block lets a host reach two internal memories through a small register window. One is a table of 128-bit lines that holds per-channel descriptors and packed 16-bit allocation entries. The other is a byte-wide data buffer. The host never addresses either memory directly. It first fills four 32-bit data words and, for table writes, four 32-bit bit-enable words. It then writes one command word that carries a direction bit, a target-select bit and an address. That command write starts a single transfer. Completion shows up as a sticky flag in a control word.

Per-bit enables let software change one 16-bit allocation entry inside a 128-bit line in one transfer, with no read-modify-write. Table reads copy the whole line into the data words. Buffer accesses move one byte through the low byte of data word 0.

Top module: `ind_ctrl_port`

## Requirements
- R1: Register index map on `reg_addr_i`: 0..3 are data words 0..3, 4..7 are enable words 0..3, 8 is the command word and 9 is the control word (bit 0 = done, other bits read 0). Indexes 0..8 read back the last accepted value. Any other index reads 0.
- R2: Command word fields: bit 31 = 1 for a write and 0 for a read. Bit 30 = 1 targets the byte buffer and 0 targets the table. Bits 29:0 are the address: a table line number, or a byte address taken modulo the buffer depth. A buffer access leaves every table line unchanged.
- R3: The done flag reads 0 in the cycle after the command write is captured and reads 1 from the second rising edge after capture.
- R4: Once set, done stays set when the control word is written with a nonzero value. A write of 0 clears it. A completion on the same edge as that write wins.
- R5: A command write captured while a transfer is in progress (the two edges after acceptance) is ignored. The command word and both memories are left as they were.
- R6: A table write changes bit i of the line (word w = i/32 holds bits 32w+31:32w) only where bit i of the enable words is 1. Every other bit keeps its value.
- R7: A table read loads the addressed line into data words 0..3, with word 0 holding line bits 31:0 and word 3 holding bits 127:96.
- R8: The table has 0x90 lines. Allocation entry n of the group based at 0x80 or 0x88 lives in line base+n/8, word (n mod 8)/2, bits starting at (n mod 2)*16. A masked write to that field alone updates exactly that entry.
- R9: A table write to a line at or above 0x90 has no effect. A table read of such a line loads zeros into all data words.
- R10: A buffer write stores bits 7:0 of data word 0 at the byte address. A buffer read loads that byte zero-extended into data word 0 and zeros into words 1..3.
- R11: After reset, every register, the done flag, all table lines and all buffer bytes are 0.
- R12: A write transfer leaves the data words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe, one write per cycle |
| reg_addr_i | input | 4 | Register index for write and readback |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register readback at `reg_addr_i` (combinational) |

## Verification
The assertions assume the host presents at most one register write per cycle. They also assume that any command landing during a busy window is a mistake the block must discard, not queue. They rely on the table write port only being driven for in-range lines, because the engine gates out-of-range addresses before the memory. The stimulus polls completion by waiting a fixed three cycles and clearing the flag before the next command. It issues exactly one overlapping command, deliberately, to exercise R5. It keeps enable words explicit before every table write, so the bit mask is always known.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
  localparam int WORD_W = 32;
  localparam int NWORDS = 4;
  localparam int LINE_W = WORD_W * NWORDS;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] RI_EN0 = 4'd4;
  localparam logic [REG_AW-1:0] RI_CMD = 4'd8;
  localparam logic [REG_AW-1:0] RI_CTL = 4'd9;

  // bit 31 write-not-read, bit 30 buffer target, 29:0 address
  typedef struct packed {
    logic        wnr;
    logic        to_buf;
    logic [29:0] addr;
  } cmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_FIN} eng_st_t;
endpackage

// File: rtl/ctp_regs.sv
module ctp_regs
  import ctp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              fin_i,
  input  logic              ld_i,
  input  logic [LINE_W-1:0] ld_line_i,
  output logic              start_o,
  output cmd_t              cmd_o,
  output logic [LINE_W-1:0] data_o,
  output logic [LINE_W-1:0] mask_o
);
  logic [NWORDS-1:0][WORD_W-1:0] data_q, en_q;
  cmd_t cmd_q;
  logic done_q;

  assign start_o = we_i && (addr_i == RI_CMD) && !busy_i;
  assign cmd_o   = cmd_q;
  assign data_o  = data_q;
  assign mask_o  = en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      en_q   <= '0;
      cmd_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (we_i) begin
        if (addr_i < RI_EN0) data_q[addr_i[1:0]] <= wdata_i;
        else if (addr_i < RI_CMD) en_q[addr_i[1:0]] <= wdata_i;
        else if (addr_i == RI_CTL && wdata_i == '0) done_q <= 1'b0;
      end
      if (start_o) cmd_q <= cmd_t'(wdata_i);
      if (ld_i) data_q <= ld_line_i;
      if (fin_i) done_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i < RI_EN0)       rdata_o = data_q[addr_i[1:0]];
    else if (addr_i < RI_CMD)  rdata_o = en_q[addr_i[1:0]];
    else if (addr_i == RI_CMD) rdata_o = cmd_q;
    else if (addr_i == RI_CTL) rdata_o = {{(WORD_W-1){1'b0}}, done_q};
  end

  // R3
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(fin_i));
  // R4
  done_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == RI_CTL && wdata_i == '0 && !fin_i) |=> !done_q);
  // R12
  wr_keeps_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_i && cmd_q.wnr && !we_i) |=> $stable(data_q));
endmodule

// File: rtl/ctp_engine.sv
module ctp_engine
  import ctp_pkg::*;
#(
  parameter int TBL_LINES = 144,
  parameter int TBL_AW    = 8,
  parameter int BUF_AW    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  cmd_t              cmd_i,
  input  logic [LINE_W-1:0] data_i,
  input  logic [LINE_W-1:0] mask_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic              ld_o,
  output logic [LINE_W-1:0] ld_line_o,
  output logic              tbl_we_o,
  output logic [TBL_AW-1:0] tbl_addr_o,
  output logic [LINE_W-1:0] tbl_wdata_o,
  output logic [LINE_W-1:0] tbl_wmask_o,
  input  logic [LINE_W-1:0] tbl_rdata_i,
  output logic              buf_we_o,
  output logic [BUF_AW-1:0] buf_addr_o,
  output logic [7:0]        buf_wdata_o,
  input  logic [7:0]        buf_rdata_i
);
  eng_st_t st_q, st_d;
  logic in_range;

  assign in_range = {2'b00, cmd_i.addr} < 32'(TBL_LINES);

  always_comb begin
    unique case (st_q)
      ST_IDLE: st_d = start_i ? ST_ACC : ST_IDLE;
      ST_ACC:  st_d = ST_FIN;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign busy_o      = st_q != ST_IDLE;
  assign fin_o       = st_q == ST_FIN;
  assign ld_o        = fin_o && !cmd_i.wnr;
  assign tbl_we_o    = (st_q == ST_ACC) && cmd_i.wnr && !cmd_i.to_buf && in_range;
  assign buf_we_o    = (st_q == ST_ACC) && cmd_i.wnr && cmd_i.to_buf;
  assign tbl_addr_o  = cmd_i.addr[TBL_AW-1:0];
  assign buf_addr_o  = cmd_i.addr[BUF_AW-1:0];
  assign tbl_wdata_o = data_i;
  assign tbl_wmask_o = mask_i;
  assign buf_wdata_o = data_i[7:0];

  always_comb begin
    if (cmd_i.to_buf)  ld_line_o = {{(LINE_W-8){1'b0}}, buf_rdata_i};
    else if (in_range) ld_line_o = tbl_rdata_i;
    else               ld_line_o = '0;
  end

  // R3
  fin_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |-> $past(start_i, 2));
  // R5
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !fin_o) |=> $stable(cmd_i));
endmodule

// File: rtl/ctp_tbl_ram.sv
module ctp_tbl_ram
  import ctp_pkg::*;
#(
  parameter int LINES = 144,
  parameter int AW    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [LINE_W-1:0] wdata_i,
  input  logic [LINE_W-1:0] wmask_i,
  output logic [LINE_W-1:0] rdata_o
);
  logic [LINE_W-1:0] mem_q [LINES];
  logic ok;

  assign ok = int'(addr_i) < LINES;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) mem_q[i] <= '0;
      rdata_o <= '0;
    end else begin
      if (we_i && ok) mem_q[addr_i] <= (mem_q[addr_i] & ~wmask_i) | (wdata_i & wmask_i);
      rdata_o <= ok ? mem_q[addr_i] : '0;
    end
  end

  // R6
  mask_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ok) |=> ((mem_q[$past(addr_i)] ^ $past(mem_q[addr_i])) & ~$past(wmask_i)) == '0);
endmodule

// File: rtl/ctp_buf_ram.sv
module ctp_buf_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_o <= '0;
    end else begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      rdata_o <= mem_q[addr_i];
    end
  end

  // R10
  byte_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/ind_ctrl_port.sv
module ind_ctrl_port
  import ctp_pkg::*;
#(
  parameter int TBL_LINES = 144,
  parameter int BUF_DEPTH = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [3:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o
);
  localparam int TBL_AW = $clog2(TBL_LINES);
  localparam int BUF_AW = $clog2(BUF_DEPTH);

  cmd_t cmd;
  logic start, busy, fin, ld;
  logic [LINE_W-1:0] data, mask, ld_line, tbl_wdata, tbl_wmask, tbl_rdata;
  logic tbl_we, buf_we;
  logic [TBL_AW-1:0] tbl_addr;
  logic [BUF_AW-1:0] buf_addr;
  logic [7:0] buf_wdata, buf_rdata;

  ctp_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy), .fin_i(fin), .ld_i(ld), .ld_line_i(ld_line),
    .start_o(start), .cmd_o(cmd), .data_o(data), .mask_o(mask)
  );

  ctp_engine #(.TBL_LINES(TBL_LINES), .TBL_AW(TBL_AW), .BUF_AW(BUF_AW)) u_eng (
    .clk_i, .rst_ni,
    .start_i(start), .cmd_i(cmd), .data_i(data), .mask_i(mask),
    .busy_o(busy), .fin_o(fin), .ld_o(ld), .ld_line_o(ld_line),
    .tbl_we_o(tbl_we), .tbl_addr_o(tbl_addr), .tbl_wdata_o(tbl_wdata),
    .tbl_wmask_o(tbl_wmask), .tbl_rdata_i(tbl_rdata),
    .buf_we_o(buf_we), .buf_addr_o(buf_addr), .buf_wdata_o(buf_wdata),
    .buf_rdata_i(buf_rdata)
  );

  ctp_tbl_ram #(.LINES(TBL_LINES), .AW(TBL_AW)) u_tbl (
    .clk_i, .rst_ni,
    .we_i(tbl_we), .addr_i(tbl_addr), .wdata_i(tbl_wdata), .wmask_i(tbl_wmask),
    .rdata_o(tbl_rdata)
  );

  ctp_buf_ram #(.DEPTH(BUF_DEPTH), .AW(BUF_AW)) u_buf (
    .clk_i, .rst_ni,
    .we_i(buf_we), .addr_i(buf_addr), .wdata_i(buf_wdata), .rdata_o(buf_rdata)
  );
endmodule

// File: tb/tb_ind_ctrl_port.sv
module tb_ind_ctrl_port;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic [127:0]      m_tbl [144];
  logic [7:0]        m_buf [256];
  logic [3:0][31:0]  m_dat, m_en;

  always #5 clk_i = ~clk_i;

  ind_ctrl_port dut (.*);

  // monitor: pops one expectation per cycle
  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata_o !== e) begin
        failures++;
        $display("FAIL %s: got %h expected %h", t, reg_rdata_o, e);
      end
    end
  end

  task automatic wr(input logic [3:0] idx, input logic [31:0] v);
    reg_we_i = 1'b1; reg_addr_i = idx; reg_wdata_i = v;
    @(negedge clk_i); #1;
    reg_we_i = 1'b0;
  endtask

  task automatic chk(input logic [3:0] idx, input logic [31:0] e, input string t);
    reg_addr_i = idx;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk_i); #1;
  endtask

  task automatic set_reg(input int idx, input logic [31:0] v);
    wr(4'(idx), v);
    if (idx < 4) m_dat[idx] = v;
    else if (idx < 8) m_en[idx-4] = v;
  endtask

  task automatic xfer(input bit wnr, input bit tobuf, input int a);
    wr(4'd8, {wnr, tobuf, 30'(a)});
    repeat (3) begin @(negedge clk_i); #1; end
    wr(4'd9, 32'd0);
    if (!tobuf) begin
      if (wnr) begin
        if (a < 144) m_tbl[a] = (m_tbl[a] & ~m_en) | (m_dat & m_en);
      end else m_dat = (a < 144) ? m_tbl[a] : '0;
    end else begin
      if (wnr) m_buf[a % 256] = m_dat[0][7:0];
      else m_dat = {120'd0, m_buf[a % 256]};
    end
  endtask

  task automatic chk_dat(input string t);
    for (int w = 0; w < 4; w++) chk(4'(w), m_dat[w], t);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 144; i++) m_tbl[i] = '0;
    for (int i = 0; i < 256; i++) m_buf[i] = '0;
    m_dat = '0; m_en = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;

    // R11 reset state of every register
    for (int i = 0; i < 10; i++) chk(4'(i), 32'd0, "R11 reset reg");
    // R1 unmapped index
    chk(4'd12, 32'd0, "R1 unmapped");

    // R1 readback of data and enable words
    set_reg(0, 32'h1111_0000); set_reg(1, 32'h2222_0001);
    set_reg(2, 32'h3333_0002); set_reg(3, 32'h4444_0003);
    for (int i = 4; i < 8; i++) set_reg(i, 32'hFFFF_FFFF);
    chk(4'd2, 32'h3333_0002, "R1 data word");
    chk(4'd6, 32'hFFFF_FFFF, "R1 enable word");

    // R11 table starts cleared: read line 0x40
    xfer(0, 0, 'h40);
    chk_dat("R11 table cleared");

    // R3 timing on a full-mask write to line 5
    set_reg(0, 32'hA5A5_0005); set_reg(3, 32'h5A5A_0505);
    wr(4'd8, {1'b1, 1'b0, 30'd5});
    chk(4'd9, 32'd0, "R3 done low after one edge");
    chk(4'd9, 32'd1, "R3 done high after two edges");
    m_tbl[5] = (m_tbl[5] & ~m_en) | (m_dat & m_en);
    // R4 nonzero write keeps done, zero clears
    wr(4'd9, 32'h0000_0006);
    chk(4'd9, 32'd1, "R4 nonzero keeps done");
    wr(4'd9, 32'd0);
    chk(4'd9, 32'd0, "R4 zero clears done");
    // R12 data words unchanged by write transfer
    chk_dat("R12 data kept");

    // R7 read line 5 after scrambling data words
    set_reg(0, 32'h0); set_reg(1, 32'h0); set_reg(2, 32'h0); set_reg(3, 32'h0);
    xfer(0, 0, 5);
    chk(4'd0, 32'hA5A5_0005, "R7 word0 low bits");
    chk(4'd3, 32'h5A5A_0505, "R7 word3 high bits");

    // R8/R6 entry 11 of group 0x88: line 0x89, word 1, bits 31:16
    set_reg(0, 32'hDEAD_BEEF); set_reg(1, 32'hCAFE_F00D);
    set_reg(2, 32'h0123_4567); set_reg(3, 32'h89AB_CDEF);
    xfer(1, 0, 'h89);
    for (int i = 4; i < 8; i++) set_reg(i, 32'h0);
    set_reg(5, 32'hFFFF_0000);
    set_reg(1, 32'h7777_9999); set_reg(0, 32'h0); set_reg(2, 32'h0); set_reg(3, 32'h0);
    xfer(1, 0, 'h88 + 11/8);
    xfer(0, 0, 'h89);
    chk(4'd1, 32'h7777_F00D, "R8 entry field updated");
    chk(4'd0, 32'hDEAD_BEEF, "R6 unmasked word kept");
    chk_dat("R6 line model");

    // R5 overlapping command ignored
    for (int i = 4; i < 8; i++) set_reg(i, 32'hFFFF_FFFF);
    set_reg(0, 32'h0000_0707);
    wr(4'd8, {1'b1, 1'b0, 30'd7});
    wr(4'd8, {1'b1, 1'b0, 30'd8});
    repeat (3) begin @(negedge clk_i); #1; end
    chk(4'd8, {1'b1, 1'b0, 30'd7}, "R5 command word kept");
    wr(4'd9, 32'd0);
    m_tbl[7] = (m_tbl[7] & ~m_en) | (m_dat & m_en);
    xfer(0, 0, 8);
    chk_dat("R5 line 8 untouched");
    xfer(0, 0, 7);
    chk(4'd0, 32'h0000_0707, "R5 first command done");

    // R9 out-of-range line
    set_reg(0, 32'h1234_5678); set_reg(2, 32'h9);
    xfer(1, 0, 'h90);
    xfer(0, 0, 'h90);
    chk_dat("R9 out of range reads zero");

    // R10 buffer byte write and read
    set_reg(0, 32'hABCD_EF34);
    xfer(1, 1, 5);
    set_reg(0, 32'hFFFF_FFFF); set_reg(1, 32'h1); set_reg(2, 32'h2); set_reg(3, 32'h3);
    xfer(0, 1, 5);
    chk(4'd0, 32'h0000_0034, "R10 byte zero-extended");
    chk(4'd1, 32'd0, "R10 upper words cleared");
    // R2 buffer write left table line 5 intact
    xfer(0, 0, 5);
    chk(4'd0, 32'hA5A5_0005, "R2 table unaffected by buffer write");
    // R2 buffer address modulo depth
    xfer(0, 1, 256 + 5);
    chk(4'd0, 32'h0000_0034, "R2 buffer address wraps");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule